// File: doc/BRIEF.md
# Command-Byte Register Access Controller

This block is the register layer that sits behind a byte-oriented I2C target. A separate bit-level engine decodes the bus and delivers single-cycle events: a start condition, a received write byte, a request for a read byte, and a stop condition. In each transaction the first written byte may be a command. When its top bit is set it either loads a register pointer together with an access mode (fixed address or auto-increment), or it issues a special function that pulses interrupt-clear strobes. Every later byte, and a first byte whose top bit is clear, is data for the register that the pointer selects.

The controller serves a 32-address map. Sixteen low addresses hold configuration bytes that the measurement logic receives as a flat bus, one address being left unmapped. A fixed identification byte, a status byte built from live flag inputs, and five 16-bit result words (as low/high byte pairs) complete the map. Reading the low byte of a result pair copies its high byte into a shadow. A later read of the high byte returns that shadow, so a 16-bit value read in two bus accesses stays coherent while new results land.

Top module: `cmd_reg_access`

## Requirements
- R1: A first write byte in a transaction with bit 7 set and bits 6:5 equal to 00 or 01 loads the pointer from bits 4:0 and the mode from bit 5 (00 fixed, 01 auto-increment), and writes no register.
- R2: In fixed mode every data write and every read in the transaction goes to the same address.
- R3: In auto-increment mode the pointer advances by one after each data write or read and wraps from 0x1F to 0x00.
- R4: A command with bits 6:5 equal to 11 is a special function: code 00101 in bits 4:0 pulses the proximity clear output, 00110 pulses the light clear output, 00111 pulses both, each high for exactly the one cycle after the byte; any other code pulses nothing. Bits 6:5 equal to 10, and all special functions, leave pointer and mode unchanged.
- R5: A first write byte with bit 7 clear is written as data at the remembered pointer, using the remembered mode.
- R6: A read uses the remembered pointer even when the transaction carries no command; `rd_byte` takes the value in the cycle after `bus_rd` and holds it until the next read.
- R7: After reset the pointer is 0x00 in fixed mode, address 0x00 holds 0x00, addresses 0x01 and 0x03 hold 0xFF, and all other configuration bytes hold 0x00.
- R8: Address 0x12 reads 0x69 and address 0x13 reads {0, 0, proximity interrupt, light interrupt, 0, 0, proximity valid, light valid} (bits 5, 4, 1, 0); writes to either have no effect.
- R9: Reading address 0x14+2k returns the low byte of result word k and captures its high byte; reading 0x15+2k returns the captured byte even when the result input has changed since.
- R10: Addresses 0x02, 0x10, 0x11, 0x1E and 0x1F read as zero and ignore writes; the other addresses below 0x10 read back the last byte written.
- R11: Byte i of `cfg_bytes` equals configuration address i and changes in the cycle after the data write that targets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Start condition seen (one-cycle pulse) |
| bus_wr | input | 1 | A write byte has been received (one-cycle pulse) |
| bus_wr_byte | input | 8 | The received write byte |
| bus_rd | input | 1 | The target must supply a read byte (one-cycle pulse) |
| bus_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| rd_byte | output | 8 | Byte to shift out, valid the cycle after `bus_rd` |
| res_words | input | 80 | Five 16-bit result words, word k in bits 16k+15:16k |
| prox_int_flag | input | 1 | Proximity interrupt pending |
| light_int_flag | input | 1 | Light interrupt pending |
| prox_valid | input | 1 | Proximity result valid |
| light_valid | input | 1 | Light result valid |
| clr_prox_int | output | 1 | One-cycle proximity interrupt clear strobe |
| clr_light_int | output | 1 | One-cycle light interrupt clear strobe |
| cfg_bytes | output | 128 | Configuration bytes, address i in bits 8i+7:8i |

## Verification
On every cycle the checker confirms that the clear strobes last one cycle and follow only a write byte of the special-function pattern, that configuration bytes move only after a write, and that the read byte moves only after a read request. Whether the right address was hit, auto-increment wrapping, the command-versus-data decision on the first byte, shadow coherence across changing results and the reset contents can only be seen through the bench's transaction sequences, which compare every read and every strobe against a reference model of the map.

// File: rtl/cmd_reg_pkg.sv
// Shared constants and types for the command-byte register controller.
// Assumes an 8-bit bus byte and a 5-bit register address space.
package cmd_reg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    // Transaction type carried in bits 6:5 of a command byte.
    typedef enum logic [1:0] {
        XT_FIXED   = 2'b00,
        XT_AUTO    = 2'b01,
        XT_RSVD    = 2'b10,
        XT_SPECIAL = 2'b11
    } xfer_type_e;

    // Decoded view of one write byte.
    typedef struct packed {
        logic             is_cmd;
        xfer_type_e       xtype;
        logic [ADDR_W-1:0] field;
    } cmd_fields_t;

    // Special-function codes.
    localparam logic [ADDR_W-1:0] SF_CLR_PROX  = 5'b00101;
    localparam logic [ADDR_W-1:0] SF_CLR_LIGHT = 5'b00110;
    localparam logic [ADDR_W-1:0] SF_CLR_BOTH  = 5'b00111;

    // Status byte bit positions.
    localparam int ST_PROX_INT  = 5;
    localparam int ST_LIGHT_INT = 4;
    localparam int ST_PROX_VAL  = 1;
    localparam int ST_LIGHT_VAL = 0;

    // Configuration indices with non-zero reset values.
    localparam int CFG_INTEG_IDX = 1;
    localparam int CFG_WAIT_IDX  = 3;

endpackage

// File: rtl/cmd_byte_decode.sv
// Splits a write byte into command fields and classifies it.
// Assumes the caller marks whether this is the first write of a transaction.
module cmd_byte_decode
    import cmd_reg_pkg::*;
(
    input  logic              wr_stb,
    input  logic              first_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    output cmd_fields_t       fields,
    output logic              load_ptr,
    output logic              data_wr,
    output logic              pulse_prox,
    output logic              pulse_light
);

    // Classify the byte as pointer load, special function or data.
    always_comb begin
        fields.is_cmd = wr_stb && first_wr && wr_byte[BYTE_W-1];
        fields.xtype  = xfer_type_e'(wr_byte[6:5]);
        fields.field  = wr_byte[ADDR_W-1:0];

        load_ptr    = fields.is_cmd &&
                      (fields.xtype == XT_FIXED || fields.xtype == XT_AUTO);
        data_wr     = wr_stb && !fields.is_cmd;
        pulse_prox  = fields.is_cmd && (fields.xtype == XT_SPECIAL) &&
                      (fields.field == SF_CLR_PROX || fields.field == SF_CLR_BOTH);
        pulse_light = fields.is_cmd && (fields.xtype == XT_SPECIAL) &&
                      (fields.field == SF_CLR_LIGHT || fields.field == SF_CLR_BOTH);
    end

endmodule

// File: rtl/cfg_reg_bank.sv
// Writable configuration bytes at addresses 0..N_CFG-1, one address left
// unmapped. Assumes N_CFG is a power of two no larger than the address space.
module cfg_reg_bank
    import cmd_reg_pkg::*;
#(
    parameter int N_CFG    = 16,
    parameter int HOLE_IDX = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    output logic                    hit,
    output logic [N_CFG*BYTE_W-1:0] cfg_flat
);

    localparam int IDX_W = $clog2(N_CFG);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(N_CFG);

    logic [BYTE_W-1:0] cfg_q [N_CFG];

    function automatic logic [BYTE_W-1:0] reset_value(int idx);
        return (idx == CFG_INTEG_IDX || idx == CFG_WAIT_IDX) ? 8'hFF : 8'h00;
    endfunction

    for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
        if (i == HOLE_IDX) begin : g_hole
            // Unmapped slot: constant zero.
            assign cfg_q[i] = '0;
        end else begin : g_byte
            // Hold one configuration byte; load it on a matching data write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[i] <= reset_value(i);
                else if (we && addr == MY_ADDR)
                    cfg_q[i] <= wdata;
            end
        end
        assign cfg_flat[i*BYTE_W +: BYTE_W] = cfg_q[i];
    end

    // Read side: select the addressed byte when it lies in the bank.
    always_comb begin
        hit   = addr < LIMIT;
        rdata = hit ? cfg_q[addr[IDX_W-1:0]] : '0;
    end

endmodule

// File: rtl/result_read_port.sv
// Read-only part of the map: identification, status and result pairs with
// high-byte shadows. Assumes results occupy 2*N_RES addresses from RES_BASE.
module result_read_port
    import cmd_reg_pkg::*;
#(
    parameter int               N_RES     = 5,
    parameter int               RES_BASE  = 'h14,
    parameter int               ID_ADDR   = 'h12,
    parameter int               STAT_ADDR = 'h13,
    parameter logic [BYTE_W-1:0] ID_VALUE = 8'h69
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_stb,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [N_RES*16-1:0] res_words,
    input  logic                prox_int_flag,
    input  logic                light_int_flag,
    input  logic                prox_valid,
    input  logic                light_valid,
    output logic [BYTE_W-1:0]   rdata
);

    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(ID_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic [BYTE_W-1:0] shadow_q [N_RES];
    logic [BYTE_W-1:0] pair_data [N_RES];
    logic [N_RES-1:0]  pair_hit;
    logic [BYTE_W-1:0] status_byte;

    for (genvar k = 0; k < N_RES; k++) begin : g_pair
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(RES_BASE + 2*k);
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(RES_BASE + 2*k + 1);

        // Capture the high byte whenever the low byte is read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[k] <= '0;
            else if (rd_stb && addr == A_LO)
                shadow_q[k] <= res_words[16*k+8 +: 8];
        end

        // Live low byte, shadowed high byte.
        always_comb begin
            pair_hit[k]  = (addr == A_LO) || (addr == A_HI);
            pair_data[k] = (addr == A_LO) ? res_words[16*k +: 8] : shadow_q[k];
        end
    end

    // Assemble the status byte from the live flags.
    always_comb begin
        status_byte               = '0;
        status_byte[ST_PROX_INT]  = prox_int_flag;
        status_byte[ST_LIGHT_INT] = light_int_flag;
        status_byte[ST_PROX_VAL]  = prox_valid;
        status_byte[ST_LIGHT_VAL] = light_valid;
    end

    // Select the byte for the addressed read-only location, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (addr == A_ID)
            rdata = ID_VALUE;
        else if (addr == A_STAT)
            rdata = status_byte;
        for (int k = 0; k < N_RES; k++)
            if (pair_hit[k])
                rdata = pair_data[k];
    end

endmodule

// File: rtl/cmd_reg_access.sv
// Command-byte register access controller. Interprets the first write byte
// of each transaction, keeps the pointer and access mode across
// transactions, and serves data reads and writes on the register map.
// Assumes bus events are single-cycle pulses and at most one per cycle.
module cmd_reg_access
    import cmd_reg_pkg::*;
#(
    parameter int N_CFG = 16,
    parameter int N_RES = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_start,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_wr_byte,
    input  logic                    bus_rd,
    input  logic                    bus_stop,
    output logic [7:0]              rd_byte,
    input  logic [N_RES*16-1:0]     res_words,
    input  logic                    prox_int_flag,
    input  logic                    light_int_flag,
    input  logic                    prox_valid,
    input  logic                    light_valid,
    output logic                    clr_prox_int,
    output logic                    clr_light_int,
    output logic [N_CFG*8-1:0]      cfg_bytes
);

    logic [ADDR_W-1:0] ptr_q;
    logic              auto_q;
    logic              first_q;
    cmd_fields_t       fields;
    logic              load_ptr, data_wr, pulse_prox, pulse_light;
    logic [BYTE_W-1:0] cfg_rdata, ro_rdata, mux_rdata;
    logic              cfg_hit;

    cmd_byte_decode u_decode (
        .wr_stb      (bus_wr),
        .first_wr    (first_q),
        .wr_byte     (bus_wr_byte),
        .fields      (fields),
        .load_ptr    (load_ptr),
        .data_wr     (data_wr),
        .pulse_prox  (pulse_prox),
        .pulse_light (pulse_light)
    );

    cfg_reg_bank #(.N_CFG(N_CFG)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (data_wr),
        .addr     (ptr_q),
        .wdata    (bus_wr_byte),
        .rdata    (cfg_rdata),
        .hit      (cfg_hit),
        .cfg_flat (cfg_bytes)
    );

    result_read_port #(.N_RES(N_RES)) u_ro (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_stb         (bus_rd),
        .addr           (ptr_q),
        .res_words      (res_words),
        .prox_int_flag  (prox_int_flag),
        .light_int_flag (light_int_flag),
        .prox_valid     (prox_valid),
        .light_valid    (light_valid),
        .rdata          (ro_rdata)
    );

    // Pick the configuration bank or the read-only part by address.
    always_comb mux_rdata = cfg_hit ? cfg_rdata : ro_rdata;

    // Track whether the next write is the first of the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_q <= 1'b0;
        else if (bus_start)
            first_q <= 1'b1;
        else if (bus_wr || bus_rd || bus_stop)
            first_q <= 1'b0;
    end

    // Maintain pointer and mode: load on command, advance on data in auto mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            auto_q <= 1'b0;
        end else if (load_ptr) begin
            ptr_q  <= fields.field;
            auto_q <= (fields.xtype == XT_AUTO);
        end else if ((data_wr || bus_rd) && auto_q) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    // Register the outgoing read byte on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_byte <= '0;
        else if (bus_rd)
            rd_byte <= mux_rdata;
    end

    // Drive the special-function clear strobes for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_prox_int  <= 1'b0;
            clr_light_int <= 1'b0;
        end else begin
            clr_prox_int  <= pulse_prox;
            clr_light_int <= pulse_light;
        end
    end

endmodule

// File: rtl/cmd_reg_access_chk.sv
// Protocol checker for cmd_reg_access, attached by bind.
module cmd_reg_access_chk #(
    parameter int N_CFG = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [7:0]         bus_wr_byte,
    input logic               bus_rd,
    input logic [7:0]         rd_byte,
    input logic               clr_prox_int,
    input logic               clr_light_int,
    input logic [N_CFG*8-1:0] cfg_bytes
);

    // Clear strobes are single-cycle pulses (R4).
    p_clr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_prox_int || clr_light_int) |=> !(clr_prox_int || clr_light_int));

    // A clear strobe follows only a write byte of the special pattern (R4).
    p_clr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_prox_int || clr_light_int) |->
            ($past(bus_wr) && $past(bus_wr_byte[7:5]) == 3'b111));

    // Configuration bytes move only after a write byte (R11).
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_wr)) |-> $stable(cfg_bytes));

    // The read byte holds between read requests (R6).
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_rd)) |-> $stable(rd_byte));

endmodule

bind cmd_reg_access cmd_reg_access_chk #(.N_CFG(N_CFG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_wr_byte   (bus_wr_byte),
    .bus_rd        (bus_rd),
    .rd_byte       (rd_byte),
    .clr_prox_int  (clr_prox_int),
    .clr_light_int (clr_light_int),
    .cfg_bytes     (cfg_bytes)
);

// File: tb/cmd_reg_access_bench.sv
module cmd_reg_access_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_start = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_stop = 1'b0;
    logic [7:0]   bus_wr_byte = '0;
    logic [7:0]   rd_byte;
    logic [79:0]  res_words = '0;
    logic         prox_int_flag = 1'b0, light_int_flag = 1'b0;
    logic         prox_valid = 1'b0, light_valid = 1'b0;
    logic         clr_prox_int, clr_light_int;
    logic [127:0] cfg_bytes;

    int checks = 0;
    int failures = 0;

    // Reference model state.
    logic [7:0] m_cfg [16];
    logic [7:0] m_shadow [5];
    logic [4:0] m_ptr;
    bit         m_auto;
    bit         m_first;

    always #2 clk = ~clk;

    cmd_reg_access u_cmd_reg_access (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_wr(bus_wr),
        .bus_wr_byte(bus_wr_byte), .bus_rd(bus_rd), .bus_stop(bus_stop),
        .rd_byte(rd_byte), .res_words(res_words),
        .prox_int_flag(prox_int_flag), .light_int_flag(light_int_flag),
        .prox_valid(prox_valid), .light_valid(light_valid),
        .clr_prox_int(clr_prox_int), .clr_light_int(clr_light_int),
        .cfg_bytes(cfg_bytes)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [4:0] a);
        if (a < 5'd16) return (a == 5'd2) ? 8'h00 : m_cfg[a[3:0]];
        if (a == 5'h12) return 8'h69;
        if (a == 5'h13) return {2'b00, prox_int_flag, light_int_flag, 2'b00, prox_valid, light_valid};
        if (a >= 5'h14 && a <= 5'h1D) begin
            int k = (int'(a) - 'h14) / 2;
            if (a[0] == 1'b0) return res_words[16*k +: 8];
            return m_shadow[k];
        end
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_cfg[i] = (i == 1 || i == 3) ? 8'hFF : 8'h00;
        for (int k = 0; k < 5; k++) m_shadow[k] = 8'h00;
        m_ptr = '0; m_auto = 0; m_first = 0;
    endtask

    task automatic t_start();
        bus_start = 1'b1; @(posedge clk); @(negedge clk); bus_start = 1'b0;
        m_first = 1;
    endtask

    task automatic t_stop();
        bus_stop = 1'b1; @(posedge clk); @(negedge clk); bus_stop = 1'b0;
        m_first = 0;
    endtask

    task automatic t_wr(input logic [7:0] b, input string tag);
        bit ep = 0, el = 0;
        if (m_first && b[7]) begin
            if (b[6:5] == 2'b00 || b[6:5] == 2'b01) begin
                m_ptr = b[4:0]; m_auto = b[5];
            end else if (b[6:5] == 2'b11) begin
                ep = (b[4:0] == 5'b00101 || b[4:0] == 5'b00111);
                el = (b[4:0] == 5'b00110 || b[4:0] == 5'b00111);
            end
        end else begin
            if (m_ptr < 5'd16 && m_ptr != 5'd2) m_cfg[m_ptr[3:0]] = b;
            if (m_auto) m_ptr = m_ptr + 5'd1;
        end
        m_first = 0;
        bus_wr = 1'b1; bus_wr_byte = b;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        chk({31'd0, clr_prox_int},  {31'd0, ep}, {tag, " R4 prox clear"});
        chk({31'd0, clr_light_int}, {31'd0, el}, {tag, " R4 light clear"});
    endtask

    task automatic t_rd(input string tag);
        logic [7:0] exp;
        exp = model_read(m_ptr);
        if (m_ptr >= 5'h14 && m_ptr <= 5'h1D && m_ptr[0] == 1'b0)
            m_shadow[(int'(m_ptr) - 'h14) / 2] = res_words[16*((int'(m_ptr) - 'h14) / 2) + 8 +: 8];
        if (m_auto) m_ptr = m_ptr + 5'd1;
        m_first = 0;
        bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        chk({24'd0, rd_byte}, {24'd0, exp}, tag);
    endtask

    task automatic chk_cfg(input string tag);
        for (int i = 0; i < 16; i++)
            chk({24'd0, cfg_bytes[8*i +: 8]}, {24'd0, (i == 2) ? 8'h00 : m_cfg[i]}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset contents and pointer.
        chk({24'd0, cfg_bytes[7:0]},   32'h00, "R7 enable reset");
        chk({24'd0, cfg_bytes[15:8]},  32'hFF, "R7 integration reset");
        chk({24'd0, cfg_bytes[31:24]}, 32'hFF, "R7 wait reset");
        chk_cfg("R7 cfg reset");
        t_start(); t_rd("R6 R7 read at reset pointer"); t_stop();

        // R1, R2: fixed mode writes land on one address.
        t_start(); t_wr(8'h81, "R1 cmd"); t_wr(8'h40, "R2 w"); t_wr(8'h41, "R2 w"); t_stop();
        chk({24'd0, cfg_bytes[15:8]}, 32'h41, "R2 fixed write");
        t_start(); t_rd("R6 read without command"); t_rd("R2 repeat read"); t_stop();

        // R3, R11: auto-increment writes.
        t_start(); t_wr(8'hA4, "R1 cmd"); t_wr(8'h11, "R3 w"); t_wr(8'h22, "R3 w"); t_wr(8'h33, "R3 w"); t_stop();
        chk({24'd0, cfg_bytes[55:48]}, 32'h33, "R3 R11 third byte");
        chk_cfg("R11 after auto writes");

        // R3, R10: wrap from 0x1F to 0x00.
        t_start(); t_wr(8'hBF, "R1 cmd"); t_rd("R10 R3 read 0x1F"); t_rd("R3 wrap to 0x00"); t_stop();

        // R5: first byte with bit 7 clear is data.
        t_start(); t_wr(8'h86, "R1 cmd"); t_stop();
        t_start(); t_wr(8'h5A, "R5 data first"); t_stop();
        chk({24'd0, cfg_bytes[55:48]}, 32'h5A, "R5 write at remembered pointer");

        // R8: identification and status are read-only.
        t_start(); t_wr(8'h92, "R1 cmd"); t_wr(8'h00, "R8 write id"); t_stop();
        t_start(); t_rd("R8 id"); t_stop();
        chk({24'd0, rd_byte}, 32'h69, "R8 id value");
        prox_int_flag = 1; light_valid = 1;
        t_start(); t_wr(8'h93, "R1 cmd"); t_wr(8'hFF, "R8 write status"); t_rd("R8 status"); t_stop();
        chk({24'd0, rd_byte}, 32'h21, "R8 status bits");

        // R4: special functions and the reserved type.
        t_start(); t_wr(8'h81, "R1 cmd"); t_stop();
        t_start(); t_wr(8'hE5, "R4 prox"); t_stop();
        t_start(); t_wr(8'hE6, "R4 light"); t_stop();
        t_start(); t_wr(8'hE7, "R4 both"); t_stop();
        chk({30'd0, clr_prox_int, clr_light_int}, 32'h0, "R4 strobe one cycle");
        t_start(); t_wr(8'hE0, "R4 no-op"); t_stop();
        t_start(); t_wr(8'hC3, "R4 reserved"); t_rd("R4 pointer kept"); t_stop();

        // R9: shadow coherence.
        res_words[15:0] = 16'h1234;
        t_start(); t_wr(8'hB4, "R1 cmd"); t_rd("R9 low");
        res_words[15:0] = 16'hABCD;
        t_rd("R9 high from shadow"); t_stop();
        chk({24'd0, rd_byte}, 32'h12, "R9 shadow value");

        // R10: unmapped addresses.
        t_start(); t_wr(8'h82, "R1 cmd"); t_wr(8'h77, "R10 w"); t_rd("R10 hole"); t_stop();
        t_start(); t_wr(8'h90, "R1 cmd"); t_wr(8'h77, "R10 w"); t_rd("R10 0x10"); t_stop();
        chk_cfg("R10 R11 cfg after unmapped writes");

        // Random transactions against the model.
        for (int n = 0; n < 400; n++) begin
            int nb;
            res_words = {$urandom, $urandom, $urandom};
            {prox_int_flag, light_int_flag, prox_valid, light_valid} = 4'($urandom);
            t_start();
            case ($urandom_range(0, 3))
                0: t_wr({3'b100, 5'($urandom)}, "R1 random cmd");
                1: t_wr({3'b101, 5'($urandom)}, "R1 random cmd");
                2: t_wr(8'($urandom), "R5 random first");
                default: ;
            endcase
            nb = $urandom_range(0, 4);
            for (int j = 0; j < nb; j++) begin
                if ($urandom_range(0, 1) == 0) t_rd("R2 R3 R9 random read");
                else t_wr({1'b0, 7'($urandom)}, "R5 random write");
                if ($urandom_range(0, 3) == 0) res_words[15:0] = 16'($urandom);
            end
            t_stop();
        end
        chk_cfg("R11 cfg after random");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule